// File: doc/BRIEF.md
# Serial Controller Command Front End

This block sits between a CPU bus and the engines of a bit-oriented synchronous serial controller. The host writes an opcode byte to a command strobe, then feeds any bytes that opcode needs through a parameter strobe. It reads back a status byte and an immediate result byte. The block decodes each opcode and knows how many parameter bytes to expect. It keeps four mode registers that are changed only through OR-mask and AND-mask opcodes. It answers the two port-read opcodes through the immediate result register. It hands frame commands to a transmit or receive engine through a one-cycle start strobe, which carries the opcode and the packed parameter bytes.

The controller is full duplex, but there is a single command path. While a command sequence is in progress, a further opcode write is dropped. Interrupt flags and result-availability flags come from the engines and appear unchanged in the low half of the status byte.

Top module: `sercmd_front`

## Requirements
- R1: After reset the status byte, the result byte and all four mode registers are zero. Status bits are: 7 busy, 6 command byte pending, 5 parameter byte pending, 4 immediate result waiting. Bits 3, 2, 1 and 0 mirror the inputs rx_int_i, tx_int_i, rx_res_av_i and tx_res_av_i.
- R2: A command write sets busy and command-pending at the next edge. Command-pending clears one cycle later, when the opcode is decoded.
- R3: A command write while busy is set has no effect on the sequence in progress. This includes the wait for the engine to acknowledge.
- R4: A parameter write while no command is waiting for parameters is discarded. It changes no mode register and no status bit.
- R5: The set opcodes OR their one parameter byte into a mode register: 91h into the operating mode, A0h into the serial I/O mode, 97h into the transfer mode and A4h into the bit-delay mode. Only bits 5..0, 2..0, 0 and 7 of those registers are kept, and the other bits read as zero.
- R6: The reset opcodes 51h, 60h, 57h and 64h AND their one parameter byte into the same four registers, in that order.
- R7: Opcode 22h loads {000, modem_in_i[4:0]} into the result byte. Opcode 23h loads modem_out_i with only bits 5, 2 and 0 kept. Either one sets result-waiting, and a result read clears it.
- R8: Frame opcodes take these parameter counts: C0h takes 2, C1h 4, C8h 4, C9h 2, and C5h, CCh and CDh take none. Once the last byte is consumed, start_o is high for exactly one cycle. start_op_o then carries the opcode and start_par_o the bytes, the first byte in bits 7..0 and unused bytes zero.
- R9: For a frame opcode busy stays high until start_ack_i is seen, and drops on the next edge.
- R10: Any opcode not listed in R5 to R8 finishes within three cycles. It produces no start strobe, no result and no mode register change.
- R11: A parameter write sets parameter-pending at the next edge, and it clears one cycle later when the byte is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_i | input | 1 | Command byte write strobe |
| par_wr_i | input | 1 | Parameter byte write strobe |
| wdata_i | input | 8 | Write data byte |
| res_rd_i | input | 1 | Immediate result read strobe |
| status_o | output | 8 | Status byte |
| result_o | output | 8 | Immediate result byte |
| rx_int_i | input | 1 | Receive interrupt flag from engine |
| tx_int_i | input | 1 | Transmit interrupt flag from engine |
| rx_res_av_i | input | 1 | Receive result available from engine |
| tx_res_av_i | input | 1 | Transmit result available from engine |
| modem_in_i | input | 5 | Modem input port value |
| modem_out_i | input | 8 | Modem output port value |
| start_o | output | 1 | Frame command start strobe |
| start_op_o | output | 8 | Opcode tag for the engine |
| start_par_o | output | 32 | Packed parameter bytes |
| start_ack_i | input | 1 | Engine acknowledge of start |
| opmode_o | output | 8 | Operating mode register |
| sio_o | output | 8 | Serial I/O mode register |
| xfer_o | output | 8 | Transfer mode register |
| bitdly_o | output | 8 | One-bit delay mode register |

## Verification
The hardest case to reach is a command write arriving while a frame command waits for its acknowledge, followed by a stray parameter byte. The bench holds start_ack_i low and issues a reset-mask opcode with a zero mask into that window. It then checks that the bit-delay register, the strobe count and busy are unaffected once the acknowledge is given. Unknown opcodes are covered by a sweep over all 256 byte values that skips the listed ones. Each of those is checked for finishing quietly.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

   typedef enum logic [1:0] {
      K_NONE,
      K_MASK,
      K_PORT,
      K_FRAME
   } cmd_kind_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_DEC,
      S_PAR,
      S_EXEC,
      S_WAIT
   } seq_state_t;

   localparam int NUM_MODE = 4;

endpackage

// File: rtl/sercmd_decode.sv
module sercmd_decode
   import sercmd_pkg::*;
#(
   parameter int DW   = 8,
   parameter int MAXP = 4,
   localparam int CW  = $clog2(MAXP + 1)
) (
   input  logic [DW-1:0] op_i,
   output cmd_kind_t     kind_o,
   output logic [CW-1:0] need_o,
   output logic [1:0]    rsel_o,
   output logic          rset_o,
   output logic          psel_o
);

   always_comb begin
      kind_o = K_NONE;
      need_o = '0;
      rsel_o = 2'd0;
      rset_o = 1'b0;
      psel_o = 1'b0;
      case (op_i)
         8'h91: begin kind_o = K_MASK; need_o = CW'(1); rsel_o = 2'd0; rset_o = 1'b1; end
         8'h51: begin kind_o = K_MASK; need_o = CW'(1); rsel_o = 2'd0; end
         8'hA0: begin kind_o = K_MASK; need_o = CW'(1); rsel_o = 2'd1; rset_o = 1'b1; end
         8'h60: begin kind_o = K_MASK; need_o = CW'(1); rsel_o = 2'd1; end
         8'h97: begin kind_o = K_MASK; need_o = CW'(1); rsel_o = 2'd2; rset_o = 1'b1; end
         8'h57: begin kind_o = K_MASK; need_o = CW'(1); rsel_o = 2'd2; end
         8'hA4: begin kind_o = K_MASK; need_o = CW'(1); rsel_o = 2'd3; rset_o = 1'b1; end
         8'h64: begin kind_o = K_MASK; need_o = CW'(1); rsel_o = 2'd3; end
         8'hC0, 8'hC9:        begin kind_o = K_FRAME; need_o = CW'(2); end
         8'hC1, 8'hC8:        begin kind_o = K_FRAME; need_o = CW'(4); end
         8'hC5, 8'hCC, 8'hCD: begin kind_o = K_FRAME; need_o = '0; end
         8'h22: begin kind_o = K_PORT; end
         8'h23: begin kind_o = K_PORT; psel_o = 1'b1; end
         default: ;
      endcase
   end

endmodule

// File: rtl/sercmd_modereg.sv
module sercmd_modereg #(
   parameter int          DW   = 8,
   parameter logic [7:0]  KEEP = 8'hFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic          set_i,
   input  logic [DW-1:0] val_i,
   output logic [DW-1:0] q_o
);

   localparam logic [DW-1:0] KMASK = DW'(KEEP);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q_o <= '0;
      else if (we_i)
         q_o <= set_i ? ((q_o | val_i) & KMASK) : (q_o & val_i & KMASK);
   end

   // R4
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o));

   // R6
   clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !set_i) |=> ((q_o & ~$past(q_o)) == '0));

endmodule

// File: rtl/sercmd_seq.sv
module sercmd_seq
   import sercmd_pkg::*;
#(
   parameter int DW   = 8,
   parameter int MAXP = 4,
   localparam int CW  = $clog2(MAXP + 1),
   localparam int IW  = (MAXP > 1) ? $clog2(MAXP) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_wr_i,
   input  logic               par_wr_i,
   input  logic [DW-1:0]      wdata_i,
   input  logic               res_rd_i,
   output logic [DW-1:0]      cmd_q_o,
   input  cmd_kind_t          kind_i,
   input  logic [CW-1:0]      need_i,
   input  logic [DW-1:0]      port_val_i,
   output logic               busy_o,
   output logic               cbf_o,
   output logic               pbf_o,
   output logic               rbf_o,
   output logic [DW-1:0]      result_o,
   output logic               mask_we_o,
   output logic [DW-1:0]      par0_o,
   output logic               start_o,
   output logic [DW*MAXP-1:0] start_par_o,
   input  logic               start_ack_i
);

   seq_state_t                   state;
   logic [CW-1:0]                cnt;
   logic [DW-1:0]                hold;
   logic [MAXP-1:0][DW-1:0]      pbuf;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         cmd_q_o  <= '0;
         cnt      <= '0;
         hold     <= '0;
         pbuf     <= '0;
         cbf_o    <= 1'b0;
         pbf_o    <= 1'b0;
         rbf_o    <= 1'b0;
         result_o <= '0;
         start_o  <= 1'b0;
      end else begin
         start_o <= 1'b0;
         if (res_rd_i) rbf_o <= 1'b0;
         case (state)
            S_IDLE: if (cmd_wr_i) begin
               cmd_q_o <= wdata_i;
               cbf_o   <= 1'b1;
               cnt     <= '0;
               pbuf    <= '0;
               state   <= S_DEC;
            end
            S_DEC: begin
               cbf_o <= 1'b0;
               state <= (need_i == '0) ? S_EXEC : S_PAR;
            end
            S_PAR: begin
               if (pbf_o) begin
                  pbuf[cnt[IW-1:0]] <= hold;
                  cnt   <= cnt + CW'(1);
                  pbf_o <= 1'b0;
                  if (cnt + CW'(1) == need_i) state <= S_EXEC;
               end else if (par_wr_i) begin
                  hold  <= wdata_i;
                  pbf_o <= 1'b1;
               end
            end
            S_EXEC: begin
               state <= S_IDLE;
               case (kind_i)
                  K_PORT: begin
                     result_o <= port_val_i;
                     rbf_o    <= 1'b1;
                  end
                  K_FRAME: begin
                     start_o <= 1'b1;
                     state   <= S_WAIT;
                  end
                  default: ;
               endcase
            end
            S_WAIT: if (start_ack_i) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign busy_o      = (state != S_IDLE);
   assign mask_we_o   = (state == S_EXEC) && (kind_i == K_MASK);
   assign par0_o      = pbuf[0];
   assign start_par_o = pbuf;

   // R2
   cbf_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cbf_o |=> !cbf_o);

   // R11
   pbf_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pbf_o |=> !pbf_o);

   // R8
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

   // R3
   busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cmd_wr_i) |=> $stable(cmd_q_o));

   // R9
   ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT && !start_ack_i) |=> busy_o);

   // R7
   result_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_rd_i && !(state == S_EXEC && kind_i == K_PORT)) |=> !rbf_o);

endmodule

// File: rtl/sercmd_front.sv
module sercmd_front
   import sercmd_pkg::*;
#(
   parameter int DW   = 8,
   parameter int MAXP = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_wr_i,
   input  logic               par_wr_i,
   input  logic [DW-1:0]      wdata_i,
   input  logic               res_rd_i,
   output logic [DW-1:0]      status_o,
   output logic [DW-1:0]      result_o,
   input  logic               rx_int_i,
   input  logic               tx_int_i,
   input  logic               rx_res_av_i,
   input  logic               tx_res_av_i,
   input  logic [4:0]         modem_in_i,
   input  logic [DW-1:0]      modem_out_i,
   output logic               start_o,
   output logic [DW-1:0]      start_op_o,
   output logic [DW*MAXP-1:0] start_par_o,
   input  logic               start_ack_i,
   output logic [DW-1:0]      opmode_o,
   output logic [DW-1:0]      sio_o,
   output logic [DW-1:0]      xfer_o,
   output logic [DW-1:0]      bitdly_o
);

   localparam int CW = $clog2(MAXP + 1);
   localparam logic [NUM_MODE-1:0][7:0] KEEP_BITS = {8'h80, 8'h01, 8'h07, 8'h3F};

   initial begin
      assert (DW == 8) else $error("opcode decode needs byte-wide data");
      assert (MAXP >= 4) else $error("frame opcodes need four parameter slots");
   end

   cmd_kind_t                     kind;
   logic [CW-1:0]                 need;
   logic [1:0]                    rsel;
   logic                          rset, psel;
   logic [DW-1:0]                 cmd_q, par0, port_val;
   logic                          busy, cbf, pbf, rbf, mask_we;
   logic [NUM_MODE-1:0][DW-1:0]   mode_q;

   sercmd_decode #(.DW(DW), .MAXP(MAXP)) u_dec (
      .op_i   (cmd_q),
      .kind_o (kind),
      .need_o (need),
      .rsel_o (rsel),
      .rset_o (rset),
      .psel_o (psel)
   );

   sercmd_seq #(.DW(DW), .MAXP(MAXP)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_wr_i    (cmd_wr_i),
      .par_wr_i    (par_wr_i),
      .wdata_i     (wdata_i),
      .res_rd_i    (res_rd_i),
      .cmd_q_o     (cmd_q),
      .kind_i      (kind),
      .need_i      (need),
      .port_val_i  (port_val),
      .busy_o      (busy),
      .cbf_o       (cbf),
      .pbf_o       (pbf),
      .rbf_o       (rbf),
      .result_o    (result_o),
      .mask_we_o   (mask_we),
      .par0_o      (par0),
      .start_o     (start_o),
      .start_par_o (start_par_o),
      .start_ack_i (start_ack_i)
   );

   assign port_val = psel
      ? {2'b00, modem_out_i[5], 2'b00, modem_out_i[2], 1'b0, modem_out_i[0]}
      : {3'b000, modem_in_i};

   for (genvar g = 0; g < NUM_MODE; g++) begin : g_mode
      sercmd_modereg #(.DW(DW), .KEEP(KEEP_BITS[g])) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we_i  (mask_we && (rsel == 2'(g))),
         .set_i (rset),
         .val_i (par0),
         .q_o   (mode_q[g])
      );
   end

   assign opmode_o   = mode_q[0];
   assign sio_o      = mode_q[1];
   assign xfer_o     = mode_q[2];
   assign bitdly_o   = mode_q[3];
   assign start_op_o = cmd_q;
   assign status_o   = {busy, cbf, pbf, rbf, rx_int_i, tx_int_i, rx_res_av_i, tx_res_av_i};

   // R10
   no_stray_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o && !$past(start_o)) |-> busy);

endmodule

// File: tb/sim_sercmd_front.sv
`timescale 1ns/1ps
module sim_sercmd_front;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0, par_wr = 1'b0, res_rd = 1'b0, start_ack = 1'b0;
   logic [7:0]  wdata = 8'h00;
   logic        rx_int = 1'b0, tx_int = 1'b0, rx_av = 1'b0, tx_av = 1'b0;
   logic [4:0]  modem_in = 5'h00;
   logic [7:0]  modem_out = 8'h00;
   logic [7:0]  status, result, start_op, opm, sio, xfer, bdly;
   logic [31:0] start_par;
   logic        start;

   int checks = 0, fails = 0, nstarts = 0;
   bit done = 0;
   logic [7:0] em [4];
   logic [7:0] keep [4];
   logic [7:0] setop [4];
   logic [7:0] rstop [4];

   always #2 clk = ~clk;

   sercmd_front u0 (
      .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .par_wr_i(par_wr), .wdata_i(wdata),
      .res_rd_i(res_rd), .status_o(status), .result_o(result),
      .rx_int_i(rx_int), .tx_int_i(tx_int), .rx_res_av_i(rx_av), .tx_res_av_i(tx_av),
      .modem_in_i(modem_in), .modem_out_i(modem_out), .start_o(start),
      .start_op_o(start_op), .start_par_o(start_par), .start_ack_i(start_ack),
      .opmode_o(opm), .sio_o(sio), .xfer_o(xfer), .bitdly_o(bdly)
   );

   always @(posedge clk) if (rst_n && start) nstarts++;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_cmd(input logic [7:0] b);
      cmd_wr = 1'b1; wdata = b; cyc(1); cmd_wr = 1'b0;
   endtask

   task automatic wr_par(input logic [7:0] b);
      par_wr = 1'b1; wdata = b; cyc(1); par_wr = 1'b0;
   endtask

   function automatic logic [7:0] regval(input int i);
      case (i)
         0: return opm;
         1: return sio;
         2: return xfer;
         default: return bdly;
      endcase
   endfunction

   task automatic chk_regs(input string req);
      for (int i = 0; i < 4; i++) chk(regval(i) == em[i], req, regval(i), em[i]);
   endtask

   task automatic mask_cmd(input int idx, input bit set, input logic [7:0] v, input string req);
      wr_cmd(set ? setop[idx] : rstop[idx]);
      cyc(1);
      wr_par(v);
      cyc(3);
      em[idx] = set ? ((em[idx] | v) & keep[idx]) : (em[idx] & v & keep[idx]);
      chk(status[7] == 1'b0, req, status, 8'h00);
      chk_regs(req);
   endtask

   task automatic frame(input logic [7:0] op, input int n, input logic [31:0] pv);
      logic [31:0] exp_par, cap_par;
      logic [7:0]  cap_op;
      int seen;
      exp_par = 32'h0;
      for (int k = 0; k < n; k++) exp_par[8*k +: 8] = pv[8*k +: 8];
      seen = 0; cap_par = 32'h0; cap_op = 8'h00;
      wr_cmd(op);
      cyc(1);
      for (int k = 0; k < n; k++) begin
         wr_par(pv[8*k +: 8]);
         cyc(1);
      end
      for (int i = 0; i < 5; i++) begin
         if (start) begin
            if (seen == 0) begin cap_op = start_op; cap_par = start_par; end
            seen++;
         end
         cyc(1);
      end
      // R8 strobe width, tag and packed bytes
      chk(seen == 1, "R8 strobe", seen, 1);
      chk(cap_op == op, "R8 tag", cap_op, op);
      chk(cap_par == exp_par, "R8 params", cap_par, exp_par);
      // R9 busy held until acknowledge
      chk(status[7] == 1'b1, "R9 busy", status, 8'h80);
      start_ack = 1'b1; cyc(1); start_ack = 1'b0;
      chk(status[7] == 1'b0, "R9 release", status, 8'h00);
   endtask

   function automatic bit known(input logic [7:0] op);
      case (op)
         8'hA4, 8'h64, 8'h97, 8'h57, 8'h91, 8'h51, 8'hA0, 8'h60,
         8'hC0, 8'hC1, 8'hC5, 8'hC8, 8'hC9, 8'hCC, 8'hCD, 8'h22, 8'h23: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      keep  = '{8'h3F, 8'h07, 8'h01, 8'h80};
      setop = '{8'h91, 8'hA0, 8'h97, 8'hA4};
      rstop = '{8'h51, 8'h60, 8'h57, 8'h64};
      for (int i = 0; i < 4; i++) em[i] = 8'h00;

      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk(status == 8'h00, "R1 status", status, 8'h00);
      chk(result == 8'h00, "R1 result", result, 8'h00);
      chk_regs("R1 modes");
      rx_int = 1'b1; tx_av = 1'b1;
      cyc(1);
      chk(status == 8'h09, "R1 flags", status, 8'h09);
      rx_int = 1'b0; tx_av = 1'b0; tx_int = 1'b1; rx_av = 1'b1;
      cyc(1);
      chk(status == 8'h06, "R1 flags", status, 8'h06);
      tx_int = 1'b0; rx_av = 1'b0;

      // R2 and R7 with port A read
      modem_in = 5'h15;
      wr_cmd(8'h22);
      chk(status[7:6] == 2'b11, "R2 set", status, 8'hC0);
      cyc(1);
      chk(status[7:6] == 2'b10, "R2 clear", status, 8'h80);
      cyc(1);
      chk(status == 8'h10, "R7 flag", status, 8'h10);
      chk(result == 8'h15, "R7 port A", result, 8'h15);
      res_rd = 1'b1; cyc(1); res_rd = 1'b0;
      chk(status == 8'h00, "R7 read clears", status, 8'h00);
      modem_out = 8'hFF;
      wr_cmd(8'h23);
      cyc(3);
      chk(result == 8'h25, "R7 port B", result, 8'h25);
      res_rd = 1'b1; cyc(1); res_rd = 1'b0;
      chk(status[4] == 1'b0, "R7 read clears", status, 8'h00);

      // R11 parameter pending
      wr_cmd(8'h91); cyc(1);
      wr_par(8'h00);
      chk(status[5] == 1'b1, "R11 set", status, 8'h20);
      cyc(1);
      chk(status[5] == 1'b0, "R11 clear", status, 8'h00);
      cyc(2);

      // R5 unused bits stay zero
      for (int i = 0; i < 4; i++) mask_cmd(i, 1'b1, 8'hFF, "R5 keep");
      // R5 and R6 sweep
      for (int i = 0; i < 48; i++) begin
         logic [7:0] v;
         v = 8'((i * 29 + 7) ^ (i << 3));
         if ((i / 4) % 2 == 0) mask_cmd(i % 4, 1'b0, v, "R6 and");
         else mask_cmd(i % 4, 1'b1, v, "R5 or");
      end
      for (int i = 0; i < 4; i++) mask_cmd(i, 1'b1, 8'hFF, "R5 refill");

      // R4 stray parameter write
      wr_par(8'h00);
      cyc(4);
      chk(status == 8'h00, "R4 status", status, 8'h00);
      chk_regs("R4 modes");

      // R8 frame opcodes
      frame(8'hC0, 2, 32'hDDCCBBAA);
      frame(8'hC1, 4, 32'h44332211);
      frame(8'hC8, 4, 32'h8070605F);
      frame(8'hC9, 2, 32'h1234FEDC);
      frame(8'hC5, 0, 32'hFFFFFFFF);
      frame(8'hCC, 0, 32'h0);
      frame(8'hCD, 0, 32'h0);

      // R3 command during wait for acknowledge
      begin
         int s0;
         wr_cmd(8'hC5); cyc(4);
         s0 = nstarts;
         wr_cmd(8'h64); cyc(1);
         wr_par(8'h00); cyc(3);
         chk(status[7] == 1'b1, "R3 still busy", status, 8'h80);
         start_ack = 1'b1; cyc(1); start_ack = 1'b0;
         cyc(4);
         chk(status == 8'h00, "R3 idle", status, 8'h00);
         chk(bdly == em[3], "R3 mode untouched", bdly, em[3]);
         chk(nstarts == s0, "R3 no strobe", nstarts, s0);
      end

      // R10 unknown opcode sweep
      for (int op = 0; op < 256; op++) begin
         if (!known(8'(op))) begin
            int s0;
            s0 = nstarts;
            wr_cmd(8'(op));
            cyc(3);
            chk(status == 8'h00 && nstarts == s0, "R10 quiet", {status, 8'(op)}, {8'h00, 8'(op)});
         end
      end
      chk_regs("R10 modes");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule